// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block gathers up to sixty maskable request lines from peripherals and picks one to hand to the processor core. Each line has an enable bit, a pending bit and a 4-bit priority, where a smaller number means more urgent. A line with both its enable and pending bits set takes part in arbitration. The most urgent of these lines wins, and the core receives its channel number as a vector, so the core does no software lookup.

Entering a handler uses a fixed decision window. A more urgent request that arrives inside this window takes over the entry. When the window closes, the vector is frozen until the core acknowledges it. On acknowledge, the pending bit of the chosen channel is cleared and its priority is pushed onto an internal stack of active levels. A new request preempts the running handler only when it is strictly more urgent than the top of that stack. An exception-return strobe pops the stack. If a request is eligible against the restored level, its entry starts on that same clock edge (tail-chaining), with no idle cycle in between.

Software reaches every channel through a narrow register port with one write per cycle and a combinational read-back.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), core_req_o and active_o are 0, and every channel reads back as enabled=0, pending=0, priority=0.
- R2: A channel's pending bit is set at any edge where its irq_i line is high, or where a register write with cfg_op_i=2 targets it. It is cleared by a write with cfg_op_i=3 or by the core acknowledging that channel. cfg_op_i=0 writes the enable bit from cfg_wdata_i[0]. cfg_op_i=1 writes the priority from cfg_wdata_i.
- R3: Among channels that are both pending and enabled, the one with the numerically lowest priority is selected. A pending channel that is disabled never raises core_req_o.
- R4: When several selected candidates share the lowest priority value, the lowest channel number wins.
- R5: With nothing active and the block idle, core_req_o rises at the fourth clock edge after the edge that records a pending bit: one decision edge, then a 3-cycle entry window.
- R6: Inside the entry window, a pending enabled request with a strictly lower priority value replaces the vector being entered, and the timing of R5 is unchanged.
- R7: While core_req_o is high and core_ack_i is low, core_vec_o stays frozen, even if more urgent requests arrive.
- R8: An edge with core_ack_i high while core_req_o is high clears that channel's pending bit and drops core_req_o. It also sets active_o and makes active_prio_o equal to the acknowledged channel's priority.
- R9: While a handler is active, a request starts an entry only if its priority value is strictly lower than active_prio_o. An equal value waits.
- R10: Each core_eret_i edge pops one active level. active_prio_o returns to the previous level, and active_o falls when the stack becomes empty.
- R11: If a request is eligible against the level restored by core_eret_i, its entry begins on that edge, and core_req_o rises at the third edge after it.
- R12: cfg_rdata_o shows, for channel cfg_chan_i and with no clock delay, bit 5 = enable, bit 4 = pending and bits 3:0 = priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 60 | Request lines, sampled each edge |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_op_i | input | 2 | Write operation: 0 enable, 1 priority, 2 set pending, 3 clear pending |
| cfg_chan_i | input | 6 | Channel addressed by write and read |
| cfg_wdata_i | input | 4 | Write data |
| cfg_rdata_o | output | 6 | {enable, pending, priority} of cfg_chan_i |
| core_req_o | output | 1 | Vector offered to the core |
| core_vec_o | output | 6 | Channel number being offered |
| core_ack_i | input | 1 | Core accepts the offered vector |
| core_eret_i | input | 1 | Core leaves the current handler |
| active_o | output | 1 | At least one handler active |
| active_prio_o | output | 4 | Priority of the innermost active handler |

## Verification
Every result has a fixed latency. Register writes and read-back show on the edge that performs them. A fresh request raises core_req_o four edges after the edge that latches its pending bit. A tail-chained entry raises it three edges after the return strobe. An acknowledge updates active_prio_o and drops the request on its own edge. Each scenario task drives its inputs one time unit after an edge, counts edges explicitly, and samples outputs one time unit after the edge where the requirement says a change is due. It also samples one edge earlier, to confirm that the change is not early.

// File: rtl/irq_arb_pkg.sv
// Package: shared encodings for the interrupt arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_arb_pkg;

    // Register-port write operation
    typedef enum logic [1:0] {
        OP_ENABLE = 2'd0,
        OP_PRIO   = 2'd1,
        OP_PSET   = 2'd2,
        OP_PCLR   = 2'd3
    } cfg_op_e;

    // Entry sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_REQ   = 2'd2
    } ent_state_e;

endpackage

// File: rtl/irq_pend_bank.sv
// Module: per-channel enable, pending and priority storage with a
// register port and combinational read-back.
// Assumes: at most one write per cycle; channel numbers at or above
// NUM_IRQ are ignored on write and read back as zero. A hardware
// request setting pending wins over a clear in the same cycle.
module irq_pend_bank
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 60,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_IRQ-1:0]             irq_i,
    input  logic                           cfg_we_i,
    input  logic [1:0]                     cfg_op_i,
    input  logic [IDX_W-1:0]               cfg_chan_i,
    input  logic [PRIO_W-1:0]              cfg_wdata_i,
    output logic [PRIO_W+1:0]              cfg_rdata_o,
    input  logic                           ack_clr_i,
    input  logic [IDX_W-1:0]               ack_idx_i,
    output logic [NUM_IRQ-1:0]             en_o,
    output logic [NUM_IRQ-1:0]             pend_o,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_o
);

    cfg_op_e                    op;
    logic [NUM_IRQ-1:0]         wr_hit;
    logic [NUM_IRQ-1:0]         set_mask;
    logic [NUM_IRQ-1:0]         clr_mask;
    logic [NUM_IRQ-1:0]         en_q;
    logic [NUM_IRQ-1:0]         pend_q;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;

    assign op = cfg_op_e'(cfg_op_i);

    // Decode the write address and the acknowledge into per-channel masks
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            wr_hit[i]   = cfg_we_i && (cfg_chan_i == IDX_W'(i));
            set_mask[i] = wr_hit[i] && (op == OP_PSET);
            clr_mask[i] = (wr_hit[i] && (op == OP_PCLR))
                        || (ack_clr_i && (ack_idx_i == IDX_W'(i)));
        end
    end

    // Update configuration and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            prio_q <= '0;
        end else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (wr_hit[i] && (op == OP_ENABLE)) en_q[i]   <= cfg_wdata_i[0];
                if (wr_hit[i] && (op == OP_PRIO))   prio_q[i] <= cfg_wdata_i;
            end
            pend_q <= (pend_q & ~clr_mask) | irq_i | set_mask;
        end
    end

    // Read back the addressed channel
    always_comb begin
        cfg_rdata_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cfg_chan_i == IDX_W'(i)) cfg_rdata_o = {en_q[i], pend_q[i], prio_q[i]};
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign prio_o = prio_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr_i && !irq_i[0] && (ack_idx_i == '0) |=> !pend_q[0]); // R8

endmodule

// File: rtl/irq_prio_select.sv
// Module: combinational winner search over all channels.
// Picks the pending and enabled channel with the lowest priority value;
// on ties the lowest channel number wins because the scan is ascending
// and replaces only on a strictly lower value.
// Assumes: NUM_IRQ fits in IDX_W bits.
module irq_prio_select #(
    parameter int NUM_IRQ = 60,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_IRQ-1:0]             en_i,
    input  logic [NUM_IRQ-1:0]             pend_i,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
    output logic                           best_vld_o,
    output logic [IDX_W-1:0]               best_idx_o,
    output logic [PRIO_W-1:0]              best_prio_o
);

    // Ascending scan keeping the strictly smallest priority value
    always_comb begin
        best_vld_o  = 1'b0;
        best_idx_o  = '0;
        best_prio_o = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (en_i[i] && pend_i[i] && (!best_vld_o || (prio_i[i] < best_prio_o))) begin
                best_vld_o  = 1'b1;
                best_idx_o  = IDX_W'(i);
                best_prio_o = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_active_stack.sv
// Module: stack of active handler priorities, kept as a shift register
// so the top and the level below it are fixed slots.
// Assumes: push and pop never coincide; pushes are bounded by strict
// preemption so DEPTH levels suffice.
module irq_active_stack #(
    parameter int DEPTH  = 16,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    output logic              top_vld_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic              under_vld_o,
    output logic [PRIO_W-1:0] under_prio_o
);

    localparam int SP_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][PRIO_W-1:0] lvl_q;
    logic [SP_W-1:0]              sp_q;

    // Shift levels down on push, up on pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            sp_q  <= '0;
        end else if (push_i) begin
            lvl_q[0] <= push_prio_i;
            for (int i = 1; i < DEPTH; i++) lvl_q[i] <= lvl_q[i-1];
            sp_q <= sp_q + 1'b1;
        end else if (pop_i && (sp_q != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) lvl_q[i] <= lvl_q[i+1];
            lvl_q[DEPTH-1] <= '0;
            sp_q <= sp_q - 1'b1;
        end
    end

    assign top_vld_o    = (sp_q != '0);
    assign top_prio_o   = lvl_q[0];
    assign under_vld_o  = (sp_q > SP_W'(1));
    assign under_prio_o = lvl_q[1];

    AST_PUSH_ROOM:    assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (sp_q < SP_W'(DEPTH))); // R9
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (sp_q != '0)); // R10
    AST_NO_PUSH_POP:  assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R10

endmodule

// File: rtl/irq_vec_arbiter.sv
// Module: top of the vectored interrupt arbiter. Runs the entry
// sequencer (decide, fixed window with late-arrival replacement, frozen
// request), the preemption threshold against the active stack, and
// tail-chaining on exception return.
// Assumes: the core acknowledges only while core_req_o is high and does
// not acknowledge and return in the same cycle.
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 60,
    parameter int PRIO_W    = 4,
    parameter int STK_DEPTH = 16,
    parameter int ENTRY_CYC = 3,
    localparam int IDX_W    = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_op_i,
    input  logic [IDX_W-1:0]   cfg_chan_i,
    input  logic [PRIO_W-1:0]  cfg_wdata_i,
    output logic [PRIO_W+1:0]  cfg_rdata_o,
    output logic               core_req_o,
    output logic [IDX_W-1:0]   core_vec_o,
    input  logic               core_ack_i,
    input  logic               core_eret_i,
    output logic               active_o,
    output logic [PRIO_W-1:0]  active_prio_o
);

    localparam int CNT_W = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;

    logic [NUM_IRQ-1:0]             en_w;
    logic [NUM_IRQ-1:0]             pend_w;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_w;
    logic                           best_vld;
    logic [IDX_W-1:0]               best_idx;
    logic [PRIO_W-1:0]              best_prio;
    logic                           top_vld, under_vld;
    logic [PRIO_W-1:0]              top_prio, under_prio;
    logic                           lvl_vld;
    logic [PRIO_W-1:0]              lvl_prio;
    logic                           eligible;
    logic                           do_ack;
    ent_state_e                     st_q;
    logic [CNT_W-1:0]               cnt_q;
    logic [IDX_W-1:0]               ent_idx_q;
    logic [PRIO_W-1:0]              ent_prio_q;

    irq_pend_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
        .cfg_we_i(cfg_we_i), .cfg_op_i(cfg_op_i), .cfg_chan_i(cfg_chan_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .ack_clr_i(do_ack), .ack_idx_i(ent_idx_q),
        .en_o(en_w), .pend_o(pend_w), .prio_o(prio_w)
    );

    irq_prio_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) sel_i (
        .en_i(en_w), .pend_i(pend_w), .prio_i(prio_w),
        .best_vld_o(best_vld), .best_idx_o(best_idx), .best_prio_o(best_prio)
    );

    irq_active_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W)) stk_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(do_ack), .push_prio_i(ent_prio_q), .pop_i(core_eret_i),
        .top_vld_o(top_vld), .top_prio_o(top_prio),
        .under_vld_o(under_vld), .under_prio_o(under_prio)
    );

    // Threshold level: the level restored by a return in this cycle, else the top
    always_comb begin
        lvl_vld  = core_eret_i ? under_vld  : top_vld;
        lvl_prio = core_eret_i ? under_prio : top_prio;
        eligible = best_vld && (!lvl_vld || (best_prio < lvl_prio));
    end

    assign do_ack = (st_q == ST_REQ) && core_ack_i;

    // Entry sequencer: decide, window with late arrival, frozen request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            ent_idx_q  <= '0;
            ent_prio_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (eligible) begin
                        st_q       <= ST_ENTRY;
                        cnt_q      <= '0;
                        ent_idx_q  <= best_idx;
                        ent_prio_q <= best_prio;
                    end
                end
                ST_ENTRY: begin
                    if (best_vld && (best_prio < ent_prio_q)) begin
                        ent_idx_q  <= best_idx;
                        ent_prio_q <= best_prio;
                    end
                    if (cnt_q == CNT_W'(ENTRY_CYC - 1)) st_q <= ST_REQ;
                    else                                cnt_q <= cnt_q + 1'b1;
                end
                ST_REQ: begin
                    if (core_ack_i) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign core_req_o    = (st_q == ST_REQ);
    assign core_vec_o    = ent_idx_q;
    assign active_o      = top_vld;
    assign active_prio_o = top_prio;

    AST_SEL_PENDING:    assert property (@(posedge clk) disable iff (!rst_n)
        best_vld |-> |((pend_w & en_w) >> best_idx)); // R3
    AST_VEC_FROZEN:     assert property (@(posedge clk) disable iff (!rst_n)
        core_req_o && !core_ack_i |=> core_req_o && $stable(core_vec_o)); // R7
    AST_REQ_DROPS:      assert property (@(posedge clk) disable iff (!rst_n)
        core_req_o && core_ack_i |=> !core_req_o && active_o); // R8
    AST_ACK_ONLY_REQ:   assert property (@(posedge clk) disable iff (!rst_n)
        core_ack_i |-> core_req_o); // R8
    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_req_o) && active_o |-> (ent_prio_q < active_prio_o)); // R9

endmodule

// File: tb/irq_vec_arbiter_tb_top.sv
// Bench: directed scenarios, one task each, checks at fixed edge counts.
module irq_vec_arbiter_tb_top;

    localparam int NIRQ = 60;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_op = 2'd0;
    logic [5:0]      cfg_chan = 6'd0;
    logic [3:0]      cfg_wdata = 4'd0;
    logic [5:0]      cfg_rdata;
    logic            core_req;
    logic [5:0]      core_vec;
    logic            core_ack = 1'b0;
    logic            core_eret = 1'b0;
    logic            active;
    logic [3:0]      active_prio;

    int n_checks = 0;
    int n_errors = 0;

    irq_vec_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .cfg_we_i(cfg_we), .cfg_op_i(cfg_op), .cfg_chan_i(cfg_chan),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .core_req_o(core_req), .core_vec_o(core_vec),
        .core_ack_i(core_ack), .core_eret_i(core_eret),
        .active_o(active), .active_prio_o(active_prio)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        irq = '0; cfg_we = 1'b0; core_ack = 1'b0; core_eret = 1'b0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input int chan, input int op, input int data);
        cfg_we = 1'b1; cfg_op = 2'(op); cfg_chan = 6'(chan); cfg_wdata = 4'(data);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int chan, input int prio);
        cfg_write(chan, 1, prio);
        cfg_write(chan, 0, 1);
    endtask

    task automatic read_chan(input int chan, output int val);
        cfg_chan = 6'(chan);
        #1;
        val = int'(cfg_rdata);
    endtask

    task automatic pulse(input int chan);
        irq[chan] = 1'b1;
        tick(1);
        irq[chan] = 1'b0;
    endtask

    task automatic ack();
        core_ack = 1'b1;
        tick(1);
        core_ack = 1'b0;
    endtask

    task automatic eret();
        core_eret = 1'b1;
        tick(1);
        core_eret = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        int v;
        do_reset();
        check("R1 req", core_req, 0);
        check("R1 active", active, 0);
        read_chan(5, v);
        check("R1 readback", v, 0);
    endtask

    // R5, R8, R12: basic entry timing and acknowledge
    task automatic t_basic();
        int v;
        do_reset();
        setup(5, 7);
        pulse(5);
        tick(3);
        check("R5 not early", core_req, 0);
        tick(1);
        check("R5 req", core_req, 1);
        check("R5 vec", core_vec, 5);
        ack();
        check("R8 req drops", core_req, 0);
        check("R8 active", active, 1);
        check("R8 active prio", active_prio, 7);
        read_chan(5, v);
        check("R12 readback en/pend/prio", v, 'h27);
    endtask

    // R3, R4: priority order and tie break
    task automatic t_order();
        do_reset();
        setup(10, 2);
        setup(3, 2);
        irq[10] = 1'b1; irq[3] = 1'b1;
        tick(1);
        irq = '0;
        tick(4);
        check("R4 tie lower index", core_vec, 3);
        do_reset();
        setup(3, 2);
        setup(20, 1);
        irq[3] = 1'b1; irq[20] = 1'b1;
        tick(1);
        irq = '0;
        tick(4);
        check("R3 lowest value req", core_req, 1);
        check("R3 lowest value vec", core_vec, 20);
    endtask

    // R2, R3: software pending control and disabled channel
    task automatic t_soft();
        int v;
        do_reset();
        cfg_write(31, 1, 0);
        cfg_write(31, 2, 0);
        read_chan(31, v);
        check("R2 sw set pending", v, 'h10);
        tick(6);
        check("R3 disabled ignored", core_req, 0);
        cfg_write(31, 3, 0);
        read_chan(31, v);
        check("R2 sw clear pending", v, 0);
        cfg_write(31, 0, 1);
        tick(6);
        check("R2 cleared no request", core_req, 0);
        cfg_write(31, 2, 0);
        tick(3);
        check("R2 sw set not early", core_req, 0);
        tick(1);
        check("R2 sw set request", core_req, 1);
        check("R2 sw set vec", core_vec, 31);
    endtask

    // R9, R10, R11: strict preemption, return and tail-chaining
    task automatic t_preempt_chain();
        do_reset();
        setup(5, 7);
        setup(8, 7);
        setup(9, 3);
        pulse(5);
        tick(4);
        ack();
        pulse(8);
        tick(6);
        check("R9 equal does not preempt", core_req, 0);
        pulse(9);
        tick(3);
        check("R9 not early", core_req, 0);
        tick(1);
        check("R9 preempt req", core_req, 1);
        check("R9 preempt vec", core_vec, 9);
        ack();
        check("R8 nested prio", active_prio, 3);
        eret();
        check("R10 restored prio", active_prio, 7);
        check("R10 still active", active, 1);
        check("R9 equal still blocked", core_req, 0);
        eret();
        check("R10 empty", active, 0);
        tick(2);
        check("R11 not early", core_req, 0);
        tick(1);
        check("R11 chained req", core_req, 1);
        check("R11 chained vec", core_vec, 8);
    endtask

    // R6, R7: late arrival replaces, then the vector is frozen
    task automatic t_late();
        do_reset();
        setup(12, 6);
        setup(13, 1);
        setup(14, 0);
        pulse(12);
        tick(1);
        pulse(13);
        tick(1);
        check("R6 not early", core_req, 0);
        tick(1);
        check("R6 req", core_req, 1);
        check("R6 late vec", core_vec, 13);
        pulse(14);
        tick(1);
        check("R7 frozen req", core_req, 1);
        check("R7 frozen vec", core_vec, 13);
        ack();
        check("R8 late prio", active_prio, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_order();
        t_soft();
        t_preempt_chain();
        t_late();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule